// File: doc/BRIEF.md
# Tick-Synchronized Register Write Port

This block sits between a host register bus and the slow timekeeping domain of a real-time clock. Host writes aimed at the time value, alarm value, stopwatch count, interrupt enables or prescaler enable are not applied at once. They are parked in a single shadow slot, an address and data pair, and committed into the slow domain only when the next commit strobe arrives. With the prescaler enabled, that strobe is the once-per-second tick. With the prescaler disabled, it is every raw oscillator edge. Only one write can be outstanding. Any further write to a synchronized register while the slot is occupied is thrown away. The write is not queued, and it does not overwrite the parked value.

Software learns the state of the slot from a status word. One bit is high while a commit is outstanding, and a sticky bit records that a commit has completed. The sticky bit raises an interrupt when the matching bit in the committed interrupt-enable register is set. The status word is not synchronized: writing a one to its completion bit clears that bit right away. Reads of synchronized registers always return the committed copy.

Top module: `tick_sync_wport`

## Requirements
- R1: After reset, every committed register reads zero except the prescaler enable, which reads one. The pending flag, the completion flag and the interrupt are low.
- R2: A write to a synchronized register (addresses 0 time, 1 alarm, 2 stopwatch, 3 interrupt enable, 4 prescaler) while nothing is pending is captured. The pending flag, status bit 14 (0x4000), is high from the next cycle. The committed value is unchanged until the commit.
- R3: A write to any synchronized register while a write is pending is discarded. After the commit, the first write's value is in place, and the discarded one is never applied on later strobes.
- R4: With the prescaler enabled (prescaler register bit 0 = 1), a pending write commits on the clock edge where `tick_1hz` is high, and `raw_edge` has no effect.
- R5: With the prescaler disabled, a pending write commits on the clock edge where `raw_edge` is high, and `tick_1hz` has no effect. The prescaler setting in force before a commit selects the strobe for that commit.
- R6: On a commit, the pending flag drops and the completion flag, status bit 15 (0x8000), is set in the following cycle. The completion flag stays set until it is cleared.
- R7: The status register (address 5) is written without synchronization. Writing a one to bit 15 clears the completion flag from the next cycle. Writing a zero there leaves it set. A status write neither sets nor disturbs the pending write.
- R8: `irq` is high one cycle after the completion flag and bit 15 of the committed interrupt-enable register are both high. An enable write affects `irq` only after it has committed.
- R9: A read returns its data with `bus_rvalid` one cycle later. Synchronized registers return the committed value, never the parked one. The status register reads {completion, pending, 14 zeros}.
- R10: Writes to unmapped addresses (6 and 7) set no pending flag and change nothing. Reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| tick_1hz | input | 1 | One-cycle pulse of the prescaled timekeeping tick |
| raw_edge | input | 1 | One-cycle pulse per raw oscillator edge |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | High in the cycle that bus_rdata is valid |
| time_o | output | DATA_W | Committed time value |
| alarm_o | output | DATA_W | Committed alarm value |
| swcnt_o | output | CNT_W | Committed stopwatch count |
| ien_o | output | CNT_W | Committed interrupt enables |
| presc_en_o | output | 1 | Committed prescaler enable |
| write_pending_o | output | 1 | A synchronized write is waiting for its strobe |
| write_done_o | output | 1 | Sticky write-complete flag |
| irq | output | 1 | Write-complete interrupt |

## Verification
The hardest condition to reach is a second write that lands while the slot is still occupied. The commit must afterwards show only the first value, and no later strobe may apply the discarded one. The stimulus parks a write, holds back every strobe of the active kind, and then fires writes to the same register and to another one. It also pulses the inactive strobe to show that it is ignored, and only then releases a tick. The test then turns the prescaler off through the same slot, so the switch of strobe source is itself a committed write, and repeats the race on the raw edge.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned NSYNC      = 5;
  localparam int unsigned IDX_TIME   = 0;
  localparam int unsigned IDX_ALARM  = 1;
  localparam int unsigned IDX_SWCNT  = 2;
  localparam int unsigned IDX_IEN    = 3;
  localparam int unsigned IDX_PRESC  = 4;
  localparam int unsigned ADDR_STAT  = 5;
  localparam int unsigned BIT_DONE   = 15;
  localparam int unsigned BIT_PEND   = 14;

  // stored width of each synchronized register
  function automatic int unsigned reg_width(int unsigned idx, int unsigned dw, int unsigned cw);
    int unsigned w;
    case (idx)
      IDX_TIME, IDX_ALARM: w = dw;
      IDX_SWCNT, IDX_IEN:  w = cw;
      default:             w = 1;
    endcase
    return (w > dw) ? dw : w;
  endfunction

  function automatic logic is_sync(logic [ADDR_W-1:0] a);
    return (32'(a) < NSYNC);
  endfunction
endpackage

// File: rtl/tsw_shadow.sv
module tsw_shadow
  import tsw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_fire,
  output logic              pending,
  output logic [ADDR_W-1:0] sh_addr,
  output logic [DATA_W-1:0] sh_data
);
  logic accept;

  // a write is taken only into an empty slot; otherwise it is dropped
  assign accept = wr_en && is_sync(wr_addr) && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      sh_addr <= '0;
      sh_data <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      sh_addr <= wr_addr;
      sh_data <= wr_data;
    end else if (commit_fire) begin
      pending <= 1'b0;
    end
  end

  AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (rst)
    accept |=> pending); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pending && !commit_fire) |=> (pending && $stable(sh_addr) && $stable(sh_data))); // R3
  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> !pending); // R6
endmodule

// File: rtl/tsw_regfile.sv
module tsw_regfile
  import tsw_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter bit          PRESC_RST = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit_fire,
  input  logic [ADDR_W-1:0]             sh_addr,
  input  logic [DATA_W-1:0]             sh_data,
  output logic [NSYNC-1:0][DATA_W-1:0]  regs_o
);
  for (genvar i = 0; i < NSYNC; i++) begin : g_reg
    localparam int unsigned W = reg_width(i, DATA_W, CNT_W);
    localparam logic [DATA_W-1:0] MASK =
      (W >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << W) - DATA_W'(1));
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == IDX_PRESC) ? DATA_W'(PRESC_RST) : '0;
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= RST_VAL;
      else if (commit_fire && (sh_addr == ADDR_W'(i)))
        q <= sh_data & MASK;
    end
    assign regs_o[i] = q;
  end

  AST_REG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(regs_o)); // R2
endmodule

// File: rtl/tsw_status.sv
module tsw_status (
  input  logic clk,
  input  logic rst,
  input  logic commit_fire,
  input  logic clr_done,
  input  logic done_en,
  output logic done,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (commit_fire)
        done <= 1'b1;
      else if (clr_done)
        done <= 1'b0;
      irq <= done && done_en;
    end
  end

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> done); // R6
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_done && !commit_fire) |=> !done); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done && done_en)); // R8
endmodule

// File: rtl/tick_sync_wport.sv
module tick_sync_wport
  import tsw_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter bit          PRESC_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              tick_1hz,
  input  logic              raw_edge,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] time_o,
  output logic [DATA_W-1:0] alarm_o,
  output logic [CNT_W-1:0]  swcnt_o,
  output logic [CNT_W-1:0]  ien_o,
  output logic              presc_en_o,
  output logic              write_pending_o,
  output logic              write_done_o,
  output logic              irq
);
  localparam int unsigned STAT_W = BIT_DONE + 1;

  logic                         pending;
  logic [ADDR_W-1:0]            sh_addr;
  logic [DATA_W-1:0]            sh_data;
  logic [NSYNC-1:0][DATA_W-1:0] regs;
  logic                         strobe;
  logic                         commit_fire;
  logic                         stat_wr;
  logic                         clr_done;
  logic                         done;
  logic [STAT_W-1:0]            stat_word;
  logic [DATA_W-1:0]            rd_mux;

  // committed prescaler setting selects which strobe commits
  assign strobe      = regs[IDX_PRESC][0] ? tick_1hz : raw_edge;
  assign commit_fire = pending && strobe;
  assign stat_wr     = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
  assign clr_done    = stat_wr && bus_wdata[BIT_DONE];

  tsw_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_we),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .commit_fire(commit_fire),
    .pending    (pending),
    .sh_addr    (sh_addr),
    .sh_data    (sh_data)
  );

  tsw_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRESC_RST(PRESC_RST)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .commit_fire(commit_fire),
    .sh_addr    (sh_addr),
    .sh_data    (sh_data),
    .regs_o     (regs)
  );

  tsw_status u_status (
    .clk        (clk),
    .rst        (rst),
    .commit_fire(commit_fire),
    .clr_done   (clr_done),
    .done_en    (regs[IDX_IEN][BIT_DONE]),
    .done       (done),
    .irq        (irq)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_DONE] = done;
    stat_word[BIT_PEND] = pending;
    if (is_sync(bus_addr))
      rd_mux = regs[bus_addr];
    else if (bus_addr == ADDR_W'(ADDR_STAT))
      rd_mux = DATA_W'(stat_word);
    else
      rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re)
        bus_rdata <= rd_mux;
    end
  end

  assign time_o          = regs[IDX_TIME];
  assign alarm_o         = regs[IDX_ALARM];
  assign swcnt_o         = regs[IDX_SWCNT][CNT_W-1:0];
  assign ien_o           = regs[IDX_IEN][CNT_W-1:0];
  assign presc_en_o      = regs[IDX_PRESC][0];
  assign write_pending_o = pending;
  assign write_done_o    = done;

  AST_STATUS_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !pending) |=> !pending); // R7
  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !is_sync(bus_addr) && !pending) |=> !pending); // R10
  AST_RVALID: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid); // R9
endmodule

// File: tb/tick_sync_wport_test.sv
module tick_sync_wport_test;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0, tick_1hz = 1'b0, raw_edge = 1'b0;
  logic [DW-1:0] bus_rdata, time_o, alarm_o;
  logic          bus_rvalid, presc_en_o, write_pending_o, write_done_o, irq;
  logic [CW-1:0] swcnt_o, ien_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_flag = 0;

  typedef struct { logic [DW-1:0] exp; string req; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  tick_sync_wport uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .tick_1hz(tick_1hz), .raw_edge(raw_edge),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .time_o(time_o),
    .alarm_o(alarm_o), .swcnt_o(swcnt_o), .ien_o(ien_o),
    .presc_en_o(presc_en_o), .write_pending_o(write_pending_o),
    .write_done_o(write_done_o), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string req);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic pulse_raw();
    @(negedge clk); raw_edge = 1'b1;
    @(negedge clk); raw_edge = 1'b0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected rvalid", bus_rdata, '0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.req, bus_rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      check(1'b0, "watchdog", DW'(cycles), '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", time_o, '0);
    chk("R1 presc", DW'(presc_en_o), 1);
    chk("R1 pend", DW'(write_pending_o), 0);
    chk("R1 done", DW'(write_done_o), 0);
    chk("R1 irq", DW'(irq), 0);
    rd(3'd5, 32'h0, "R1 status read");

    // R2 capture
    wr(3'd0, 32'h0001_2345);
    chk("R2 pending", DW'(write_pending_o), 1);
    chk("R2 time unchanged", time_o, '0);
    rd(3'd0, 32'h0, "R9 committed not shadow");
    rd(3'd5, 32'h4000, "R2 status pending bit");

    // R3 drops while pending, R4 raw ignored
    wr(3'd0, 32'h0000_BEEF);
    wr(3'd1, 32'h0000_0007);
    pulse_raw();
    chk("R4 raw ignored pend", DW'(write_pending_o), 1);
    chk("R4 raw ignored time", time_o, '0);
    pulse_tick();
    chk("R4 tick commit", time_o, 32'h0001_2345);
    chk("R3 alarm dropped", alarm_o, '0);
    chk("R6 pend cleared", DW'(write_pending_o), 0);
    chk("R6 done set", DW'(write_done_o), 1);
    pulse_tick();
    pulse_tick();
    chk("R3 dropped never applied", time_o, 32'h0001_2345);
    chk("R6 done sticky", DW'(write_done_o), 1);

    // R8 enable only after commit
    chk("R8 irq masked", DW'(irq), 0);
    wr(3'd3, 32'h0000_8000);
    @(negedge clk);
    chk("R8 irq before enable commit", DW'(irq), 0);
    pulse_tick();
    chk("R8 ien committed", DW'(ien_o), 32'h8000);
    @(negedge clk);
    chk("R8 irq raised", DW'(irq), 1);

    // R7 status writes
    wr(3'd5, 32'h0000_0000);
    chk("R7 zero keeps done", DW'(write_done_o), 1);
    chk("R7 no pending", DW'(write_pending_o), 0);
    wr(3'd5, 32'h0000_8000);
    chk("R7 clear done", DW'(write_done_o), 0);
    @(negedge clk);
    chk("R8 irq drops", DW'(irq), 0);

    // R7 status clear while a write is pending
    wr(3'd2, 32'h0000_0055);
    wr(3'd5, 32'h0000_8000);
    chk("R7 pending kept", DW'(write_pending_o), 1);
    pulse_tick();
    chk("R7 swcnt commit", DW'(swcnt_o), 32'h55);
    chk("R6 done again", DW'(write_done_o), 1);
    wr(3'd5, 32'h0000_8000);

    // R5 prescaler off, committed on old strobe
    wr(3'd4, 32'h0);
    pulse_raw();
    chk("R5 old strobe governs", DW'(presc_en_o), 1);
    pulse_tick();
    chk("R5 presc off", DW'(presc_en_o), 0);
    wr(3'd1, 32'h0000_0ABC);
    wr(3'd1, 32'h0000_0DEF);
    pulse_tick();
    chk("R5 tick ignored", alarm_o, '0);
    chk("R5 still pending", DW'(write_pending_o), 1);
    pulse_raw();
    chk("R5 raw commit", alarm_o, 32'h0ABC);
    chk("R3 raw mode drop", DW'(write_pending_o), 0);

    // R10 unmapped
    wr(3'd6, 32'hFFFF_FFFF);
    chk("R10 no pending", DW'(write_pending_o), 0);
    rd(3'd6, 32'h0, "R10 unmapped read");
    rd(3'd1, 32'h0ABC, "R9 alarm read");
    rd(3'd2, 32'h55, "R9 swcnt read");
    rd(3'd3, 32'h8000, "R9 ien read");
    rd(3'd5, 32'h8000, "R9 status read");
    repeat (3) @(negedge clk);
    chk("R9 queue drained", DW'(sb_q.size()), 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule